// File: doc/BRIEF.md
# Multi-Lane SPI Host Controller

This block is an SPI host that owns one chip select, one serial clock and one outgoing data line, and collects data on four separate incoming lanes. Every lane has its own shift register, and all lanes shift on the same clock edges. A converter that samples four channels at once can therefore return four different words in one frame, one word on each lane. This is four parallel streams, not one stream sent faster.

Software-side logic writes words into a transmit FIFO, sets the transfer configuration and pulses `start`. The configuration is lane mode, word width, clock divider and frame count. The controller drops chip select and runs the requested number of frames back to back. It writes the received words into a receive FIFO, then raises chip select and pulses `done`. The lane mode sets how the single FIFO word stream maps onto the lanes. Single mode uses lane 0 only. Mirror mode loads one word into every lane shifter. Stripe mode hands consecutive words to consecutive lanes.

Top module: `mlspi_host`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0, and `rx_empty` is 1.
- R2: The SPI clock works in mode 0. `spi_sclk` is 0 whenever `spi_cs_n` is 1. `spi_mosi` does not change while `spi_sclk` is high. Lanes are sampled on the rising edge. Within a frame, consecutive rising edges are exactly 2×`cfg_div` clock cycles apart.
- R3: Words are `cfg_width` bits long, from 8 to 32. They are shifted MSB first. Transmit bits above `cfg_width` are ignored. Received words are right-aligned and zero-extended.
- R4: Single mode (`cfg_mode`=0, and also the value 3) pops one TX word per frame and sends it on `spi_mosi`. It pushes one RX word per frame, taken from lane 0 (`spi_miso[0]`). Lanes 1 to 3 are ignored.
- R5: Mirror mode (`cfg_mode`=1) pops one TX word per frame and loads it into every lane shifter. That word goes out on `spi_mosi`. Each frame pushes four RX words, in the order lane 0, 1, 2, 3.
- R6: Stripe mode (`cfg_mode`=2) pops four TX words per frame. Lane k takes the k-th word of the group. `spi_mosi` carries the first word of the group. Each frame pushes four RX words, in the order lane 0, 1, 2, 3.
- R7: A `start` pulse is ignored, leaving `spi_cs_n` high and `busy` low, in any of these cases:
  - the TX FIFO holds fewer words than one frame needs (4 in stripe mode, 1 otherwise);
  - the RX FIFO has less free room than one frame produces;
  - `cfg_width` is outside 8..32;
  - `cfg_div` is 0;
  - `cfg_frames` is 0.
- R8: A transfer runs exactly `cfg_frames` frames. `spi_cs_n` stays low from the first frame to the last, and rises only at the end of the transfer.
- R9: `busy` is high exactly while `spi_cs_n` is low. `done` is a one-cycle pulse in the cycle where `spi_cs_n` rises. By then every received word of the transfer is in the RX FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer with the current configuration |
| cfg_mode | input | 2 | Lane mode: 0 single, 1 mirror, 2 stripe |
| cfg_width | input | 6 | Word width in bits, 8..32 |
| cfg_div | input | 8 | SPI clock half period in system clock cycles |
| cfg_frames | input | 8 | Number of frames in the transfer |
| tx_push | input | 1 | Write `tx_data` into the TX FIFO |
| tx_data | input | 32 | Transmit word |
| tx_full | output | 1 | TX FIFO full |
| rx_pop | input | 1 | Remove the oldest RX word |
| rx_data | output | 32 | Oldest RX word (first-word fall-through) |
| rx_empty | output | 1 | RX FIFO empty |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial transmit data |
| spi_miso | input | 4 | Serial receive data, one bit per lane |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |

## Verification
The bench targets the places where lane and word ordering can slip:
- Stripe mode must send the first word of each group and return lane words in ascending order. A rotated lane index or a swapped push order shows up as exchanged words.
- Single mode must push only one word per frame. A design that pushes every lane leaves extra words behind, and `rx_empty` stays low after the expected pops.
- Widths of 8 and 32 with unmasked transmit data catch an off-by-one in the alignment shift or the receive mask.
- Start requests with too few TX words, width 7 or divider 0 must be refused. A design that accepts them drops chip select when it should not.
- Multi-frame transfers catch a chip select that toggles between frames, or a `done` pulse that fires before the last words are pushed.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

  typedef enum logic [1:0] {
    LM_SINGLE = 2'd0,
    LM_MIRROR = 2'd1,
    LM_STRIPE = 2'd2
  } lane_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SHIFT,
    S_PUSH,
    S_GAP,
    S_TRAIL
  } ctrl_state_e;

  // The unused encoding 3 falls back to single-lane operation.
  function automatic lane_mode_e mode_of(logic [1:0] raw);
    case (raw)
      2'd1:    return LM_MIRROR;
      2'd2:    return LM_STRIPE;
      default: return LM_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/mlspi_fifo.sv
module mlspi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;
  assign dout    = mem[rd_q];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push)           wr_q  <= wr_d;
      if (do_pop)            rd_q  <= rd_d;
      if (do_push ^ do_pop)  cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

endmodule

// File: rtl/mlspi_lane.sv
module mlspi_lane #(
  parameter int MAXW = 32,
  parameter int WB   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXW-1:0] word_in,
  input  logic [WB-1:0]   width,
  input  logic            sample,
  input  logic            shift,
  input  logic            miso,
  output logic            mosi,
  output logic [MAXW-1:0] rx_word
);

  logic [MAXW-1:0] sh_q, sh_d;
  logic            cap_q, cap_d;
  logic            sh_en;

  assign sh_en = load || shift;

  always_comb begin
    sh_d  = sh_q;
    cap_d = sample ? miso : cap_q;
    if (load)       sh_d = word_in << (WB'(MAXW) - width);
    else if (shift) sh_d = {sh_q[MAXW-2:0], cap_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cap_q <= 1'b0;
    end else begin
      if (sh_en)  sh_q  <= sh_d;
      if (sample) cap_q <= cap_d;
    end
  end

  assign mosi    = sh_q[MAXW-1];
  assign rx_word = sh_q & ({MAXW{1'b1}} >> (WB'(MAXW) - width));

endmodule

// File: rtl/mlspi_ctrl.sv
module mlspi_ctrl
  import mlspi_pkg::*;
#(
  parameter int LANES = 4,
  parameter int MAXW  = 32,
  parameter int DEPTH = 16,
  parameter int DIVW  = 8,
  parameter int FRW   = 8,
  localparam int WB   = $clog2(MAXW) + 1,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int SELW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [WB-1:0]    cfg_width,
  input  logic [DIVW-1:0]  cfg_div,
  input  logic [FRW-1:0]   cfg_frames,
  input  logic [CW-1:0]    tx_count,
  input  logic [CW-1:0]    rx_count,
  output logic             tx_pop,
  output logic [LANES-1:0] load_en,
  output logic             rx_push,
  output logic [SELW-1:0]  rx_sel,
  output logic             sample,
  output logic             shift,
  output logic [WB-1:0]    width,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             done
);

  ctrl_state_e     st_q, st_d;
  lane_mode_e      mode_q, mode_d, mode_sel;
  logic [WB-1:0]   width_q, width_d;
  logic [DIVW-1:0] div_q, div_d, hc_q, hc_d;
  logic [FRW-1:0]  frames_q, frames_d;
  logic [WB-1:0]   bit_q, bit_d;
  logic [SELW-1:0] idx_q, idx_d;
  logic            sclk_q, sclk_d, csn_q, csn_d, done_q, done_d;
  logic [CW-1:0]   need_tx, need_rx;
  logic            fits, cfg_ok, tick;

  // Admission: the frame about to start must find its words and room.
  assign mode_sel = (st_q == S_IDLE) ? mode_of(cfg_mode) : mode_q;
  assign need_tx  = (mode_sel == LM_STRIPE) ? CW'(LANES) : CW'(1);
  assign need_rx  = (mode_sel == LM_SINGLE) ? CW'(1) : CW'(LANES);
  assign fits     = (tx_count >= need_tx) &&
                    (({1'b0, rx_count} + {1'b0, need_rx}) <= (CW+1)'(DEPTH));
  assign cfg_ok   = (cfg_width >= WB'(8)) && (cfg_width <= WB'(MAXW)) &&
                    (cfg_div != '0) && (cfg_frames != '0);
  assign tick     = (hc_q == div_q - DIVW'(1));

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    width_d  = width_q;
    div_d    = div_q;
    frames_d = frames_q;
    hc_d     = hc_q;
    bit_d    = bit_q;
    idx_d    = idx_q;
    sclk_d   = sclk_q;
    csn_d    = csn_q;
    done_d   = 1'b0;
    tx_pop   = 1'b0;
    load_en  = '0;
    rx_push  = 1'b0;
    sample   = 1'b0;
    shift    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start && fits && cfg_ok) begin
          mode_d   = mode_of(cfg_mode);
          width_d  = cfg_width;
          div_d    = cfg_div;
          frames_d = cfg_frames;
          csn_d    = 1'b0;
          idx_d    = '0;
          st_d     = S_LOAD;
        end
      end
      S_LOAD: begin
        tx_pop = 1'b1;
        if (mode_q == LM_STRIPE) begin
          load_en = LANES'(1) << idx_q;
          idx_d   = idx_q + SELW'(1);
        end else begin
          load_en = '1;
        end
        if (mode_q != LM_STRIPE || idx_q == SELW'(LANES - 1)) begin
          st_d  = S_SHIFT;
          hc_d  = '0;
          bit_d = '0;
          idx_d = '0;
        end
      end
      S_SHIFT: begin
        if (tick) begin
          hc_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
            sample = 1'b1;
          end else begin
            sclk_d = 1'b0;
            shift  = 1'b1;
            bit_d  = bit_q + WB'(1);
            if (bit_q == width_q - WB'(1)) begin
              st_d  = S_PUSH;
              idx_d = '0;
            end
          end
        end else begin
          hc_d = hc_q + DIVW'(1);
        end
      end
      S_PUSH: begin
        rx_push = 1'b1;
        idx_d   = idx_q + SELW'(1);
        if (mode_q == LM_SINGLE || idx_q == SELW'(LANES - 1)) begin
          frames_d = frames_q - FRW'(1);
          if (frames_q == FRW'(1)) begin
            st_d = S_TRAIL;
            hc_d = '0;
          end else begin
            st_d = S_GAP;
          end
        end
      end
      S_GAP: begin
        if (fits) begin
          st_d  = S_LOAD;
          idx_d = '0;
        end
      end
      S_TRAIL: begin
        if (tick) begin
          csn_d  = 1'b1;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          hc_d = hc_q + DIVW'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      mode_q   <= LM_SINGLE;
      width_q  <= WB'(8);
      div_q    <= DIVW'(1);
      frames_q <= '0;
      hc_q     <= '0;
      bit_q    <= '0;
      idx_q    <= '0;
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      width_q  <= width_d;
      div_q    <= div_d;
      frames_q <= frames_d;
      hc_q     <= hc_d;
      bit_q    <= bit_d;
      idx_q    <= idx_d;
      sclk_q   <= sclk_d;
      csn_q    <= csn_d;
      done_q   <= done_d;
    end
  end

  assign rx_sel = idx_q;
  assign width  = width_q;
  assign cs_n   = csn_q;
  assign sclk   = sclk_q;
  assign busy   = ~csn_q;
  assign done   = done_q;

endmodule

// File: rtl/mlspi_host.sv
module mlspi_host #(
  parameter int LANES = 4,
  parameter int MAXW  = 32,
  parameter int DEPTH = 16,
  parameter int DIVW  = 8,
  parameter int FRW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            cfg_mode,
  input  logic [$clog2(MAXW):0] cfg_width,
  input  logic [DIVW-1:0]       cfg_div,
  input  logic [FRW-1:0]        cfg_frames,
  input  logic                  tx_push,
  input  logic [MAXW-1:0]       tx_data,
  output logic                  tx_full,
  input  logic                  rx_pop,
  output logic [MAXW-1:0]       rx_data,
  output logic                  rx_empty,
  output logic                  spi_cs_n,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  input  logic [LANES-1:0]      spi_miso,
  output logic                  busy,
  output logic                  done
);

  localparam int WB   = $clog2(MAXW) + 1;
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int SELW = $clog2(LANES);

  logic [CW-1:0]    tx_count, rx_count;
  logic [MAXW-1:0]  tx_dout, rx_din;
  logic             tx_pop, rx_push, sample, shift;
  logic [LANES-1:0] load_en;
  logic [SELW-1:0]  rx_sel;
  logic [WB-1:0]    width;
  logic [MAXW-1:0]  lane_rx [LANES];
  logic [LANES-1:1] msb_unused;
  logic             tx_empty_unused, rx_full_unused;

  mlspi_fifo #(.W(MAXW), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(tx_data),
    .pop(tx_pop), .dout(tx_dout),
    .count(tx_count), .full(tx_full), .empty(tx_empty_unused)
  );

  mlspi_fifo #(.W(MAXW), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_data),
    .count(rx_count), .full(rx_full_unused), .empty(rx_empty)
  );

  mlspi_ctrl #(
    .LANES(LANES), .MAXW(MAXW), .DEPTH(DEPTH), .DIVW(DIVW), .FRW(FRW)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_mode(cfg_mode), .cfg_width(cfg_width), .cfg_div(cfg_div),
    .cfg_frames(cfg_frames), .tx_count(tx_count), .rx_count(rx_count),
    .tx_pop(tx_pop), .load_en(load_en), .rx_push(rx_push), .rx_sel(rx_sel),
    .sample(sample), .shift(shift), .width(width),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .busy(busy), .done(done)
  );

  // One shifter per lane; only lane 0 has a pin toward the device input.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_tx
      mlspi_lane #(.MAXW(MAXW), .WB(WB)) i_lane (
        .clk(clk), .rst_n(rst_n), .load(load_en[k]), .word_in(tx_dout),
        .width(width), .sample(sample), .shift(shift), .miso(spi_miso[k]),
        .mosi(spi_mosi), .rx_word(lane_rx[k])
      );
    end else begin : g_rx
      mlspi_lane #(.MAXW(MAXW), .WB(WB)) i_lane (
        .clk(clk), .rst_n(rst_n), .load(load_en[k]), .word_in(tx_dout),
        .width(width), .sample(sample), .shift(shift), .miso(spi_miso[k]),
        .mosi(msb_unused[k]), .rx_word(lane_rx[k])
      );
    end
  end

  assign rx_din = lane_rx[rx_sel];

endmodule

// File: rtl/mlspi_host_chk.sv
module mlspi_host_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_sclk,
  input logic          spi_mosi,
  input logic          done,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic          rx_push,
  input logic [CW-1:0] rx_count
);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk) |-> $stable(spi_mosi));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_count != '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_count < CW'(DEPTH)));

  p_cs_rise_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);

  p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !$past(spi_cs_n)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mlspi_host mlspi_host_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .done(done), .tx_pop(tx_pop), .tx_count(tx_count),
  .rx_push(rx_push), .rx_count(rx_count)
);

// File: tb/test_mlspi_host.sv
module test_mlspi_host;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, tx_push, rx_pop;
  logic [1:0]  cfg_mode;
  logic [5:0]  cfg_width;
  logic [7:0]  cfg_div, cfg_frames;
  logic [31:0] tx_data;
  logic [3:0]  spi_miso;
  logic        tx_full, rx_empty, spi_cs_n, spi_sclk, spi_mosi, busy, done;
  logic [31:0] rx_data;

  mlspi_host i_mlspi_host (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_width(cfg_width), .cfg_div(cfg_div), .cfg_frames(cfg_frames),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .busy(busy), .done(done)
  );

  int checks = 0, errors = 0;
  int bc = 0, dframe = 0, cur_width = 8, cur_div = 1, xtag = 0;
  int per_cnt = 0, per_bad = 0, cs_rises = 0, done_cnt = 0, nmosi = 0, ntx = 0;
  logic [31:0] mcap = '0;
  logic [31:0] mosi_got [8];
  logic [31:0] txw [16];
  logic sclk_d = 1'b0, cs_d = 1'b1;

  function automatic logic [31:0] wmask(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] dev_word(int lane, int fr, int tag, int w);
    logic [31:0] h;
    h = (32'(tag) * 32'h9E37_79B1) ^ (32'(fr * 4 + lane + 1) * 32'h85EB_CA77);
    h = h ^ (h >> 13);
    h = h * 32'hC2B2_AE3D;
    return h & wmask(w);
  endfunction

  function automatic string req_of(int mode);
    return (mode == 2) ? "R6" : (mode == 1) ? "R5" : "R4";
  endfunction

  // Device model and bus monitor, all on the falling system clock edge.
  always @(negedge clk) begin
    if (!spi_cs_n) begin
      if (spi_sclk && !sclk_d) begin
        if (bc != 0 && per_cnt != 2 * cur_div) per_bad++;
        per_cnt = 0;
        mcap = {mcap[30:0], spi_mosi};
        if (bc == cur_width - 1 && dframe < 8) begin
          mosi_got[dframe] = mcap & wmask(cur_width);
          nmosi++;
        end
      end
      if (!spi_sclk && sclk_d) begin
        bc++;
        if (bc == cur_width) begin
          bc = 0;
          dframe++;
        end
      end
    end else begin
      bc = 0;
      dframe = 0;
    end
    if (spi_cs_n && !cs_d) cs_rises++;
    if (done) done_cnt++;
    per_cnt++;
    sclk_d = spi_sclk;
    cs_d = spi_cs_n;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] t;
      t = dev_word(k, dframe, xtag, cur_width);
      spi_miso[k] = spi_cs_n ? 1'b0 : t[cur_width - 1 - bc];
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_tx(logic [31:0] w);
    @(negedge clk);
    tx_push = 1'b1;
    tx_data = w;
    txw[ntx] = w;
    ntx++;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic try_start(int mode, int w, int div, int fr);
    @(negedge clk);
    cfg_mode = 2'(mode);
    cfg_width = 6'(w);
    cfg_div = 8'(div);
    cfg_frames = 8'(fr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_refused(string what);
    repeat (4) @(negedge clk);
    check(spi_cs_n && !busy, "R7", what, {30'd0, busy, spi_cs_n}, 32'd1);
  endtask

  task automatic run_xfer(int mode, int w, int div, int fr);
    int need, nrx, t;
    logic [31:0] exp;
    need = (mode == 2) ? 4 * fr : fr;
    while (ntx < need) push_tx($urandom);
    cur_width = w;
    cur_div = div;
    xtag++;
    nmosi = 0;
    per_bad = 0;
    cs_rises = 0;
    done_cnt = 0;
    try_start(mode, w, div, fr);
    repeat (2) @(negedge clk);
    check(busy && !spi_cs_n, "R9", "busy while selected", {30'd0, busy, spi_cs_n}, 32'd2);
    t = 0;
    while (!done && t < 50000) begin
      @(negedge clk);
      t++;
    end
    check(done, "R9", "done pulse seen", 32'(done), 32'd1);
    check(!rx_empty, "R9", "words present at done", 32'(rx_empty), 32'd0);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R9", "done pulse length", 32'(done_cnt), 32'd1);
    check(cs_rises == 1, "R8", "chip select rises once", 32'(cs_rises), 32'd1);
    check(nmosi == fr, "R8", "frame count", 32'(nmosi), 32'(fr));
    check(per_bad == 0, "R2", "sclk period", 32'(per_bad), 32'd0);
    for (int f = 0; f < fr && f < 8; f++) begin
      exp = ((mode == 2) ? txw[4 * f] : txw[f]) & wmask(w);
      check(mosi_got[f] === exp, req_of(mode), "mosi word (R3)", mosi_got[f], exp);
    end
    nrx = (mode == 0) ? fr : 4 * fr;
    for (int i = 0; i < nrx; i++) begin
      exp = (mode == 0) ? dev_word(0, i, xtag, w) : dev_word(i % 4, i / 4, xtag, w);
      check(rx_data === exp, req_of(mode), "rx word (R3)", rx_data, exp);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      @(negedge clk);
    end
    check(rx_empty, req_of(mode), "rx word count", 32'(rx_empty), 32'd1);
    ntx = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2026));
    rst_n = 1'b0;
    start = 1'b0;
    tx_push = 1'b0;
    rx_pop = 1'b0;
    tx_data = '0;
    cfg_mode = '0;
    cfg_width = 6'd8;
    cfg_div = 8'd1;
    cfg_frames = 8'd1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n === 1'b1, "R1", "cs_n after reset", 32'(spi_cs_n), 32'd1);
    check(spi_sclk === 1'b0, "R1", "sclk after reset", 32'(spi_sclk), 32'd0);
    check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
    check(done === 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    check(rx_empty === 1'b1, "R1", "rx_empty after reset", 32'(rx_empty), 32'd1);

    // R7 empty TX FIFO
    try_start(0, 8, 1, 1);
    expect_refused("start with empty TX");
    // R7 and R6: stripe needs four words
    for (int i = 0; i < 3; i++) push_tx($urandom);
    try_start(2, 8, 2, 1);
    expect_refused("stripe with three words");
    run_xfer(2, 16, 2, 1);
    // R7 bad width and divider
    push_tx($urandom);
    try_start(0, 7, 1, 1);
    expect_refused("width 7");
    try_start(0, 8, 0, 1);
    expect_refused("divider 0");
    try_start(0, 8, 1, 0);
    expect_refused("zero frames");
    run_xfer(0, 8, 1, 1);

    // Directed corners
    run_xfer(1, 32, 1, 2);
    run_xfer(0, 32, 3, 3);
    run_xfer(2, 8, 1, 3);
    run_xfer(1, 8, 4, 1);
    run_xfer(2, 32, 2, 2);

    // Random transfers
    for (int n = 0; n < 30; n++) begin
      run_xfer(int'($urandom % 3), 8 + int'($urandom % 25),
               1 + int'($urandom % 4), 1 + int'($urandom % 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule